// File: doc/BRIEF.md
# XON/XOFF Software Flow Detector

This block sits on the receive side of a serial port and watches every byte that arrives. When it sees the programmed pause character, it lowers a transmit-enable flag so the local transmitter stops. When it sees the programmed resume character, it raises the flag again. Each character is set up as either a single byte or a pair of bytes that must arrive back to back. A mode input chooses between the two.

Four 8-bit character registers sit behind a small write/read port. The port only accepts accesses while the line-control value presented to the block equals a key, 0xBF by default. Every received byte is passed on one cycle later without change. A one-cycle match pulse marks any byte that completed a pause or resume character. A flow-enable input turns the whole mechanism off.

Top module: `xonxoff_detector`

## Requirements
- R1: After reset all four character registers read 0x00, `tx_enable` is 1, and `xon_hit`, `xoff_hit` and `rx_out_valid` are 0.
- R2: While `lcr_val` equals 0xBF, a write stores `reg_wdata` at `reg_addr` (0 = resume byte A, 1 = resume byte B, 2 = pause byte A, 3 = pause byte B). A read strobe returns the addressed register on `reg_rdata` in the following cycle.
- R3: While `lcr_val` differs from 0xBF, a write leaves every register unchanged and a read returns 0x00.
- R4: With `two_byte`=0, a received byte equal to pause byte A suspends (`tx_enable`=0) and one equal to resume byte A resumes. Both take effect in the cycle after the byte is strobed. Bytes equal only to the B registers do nothing.
- R5: With `two_byte`=1, a pause or resume match needs byte A followed by byte B on the very next received byte.
- R6: In two-byte mode, a non-matching byte between A and B cancels the partial match. A repeated byte A restarts it, so A, A, B still matches.
- R7: When one received byte completes both a pause and a resume match, pause wins: only `xoff_hit` rises and the flag goes to 0.
- R8: While `flow_en`=0, `tx_enable` is 1 in the same cycle, no match pulse is raised, and any partial two-byte match is dropped.
- R9: Each strobed byte appears on `rx_out_data` with `rx_out_valid` high exactly one cycle later. `xon_hit`/`xoff_hit` are one-cycle pulses aligned with that output.
- R10: While `flow_en` stays 1, `tx_enable` changes only in a cycle that carries a match pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_en | input | 1 | Enables matching; 0 forces transmit enable |
| two_byte | input | 1 | 1 = two-byte characters, 0 = single byte |
| lcr_val | input | 8 | Current line-control register value (access key) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Forwarded byte strobe |
| rx_out_data | output | 8 | Forwarded byte |
| xon_hit | output | 1 | Resume character completed on this forwarded byte |
| xoff_hit | output | 1 | Pause character completed on this forwarded byte |
| tx_enable | output | 1 | 1 = local transmitter may send |

## Verification
The bench targets the partial-match state in two-byte mode. It sends an interrupted pair, which a design that never clears the pending state would accept. It sends a repeated first byte, which a design that clears without re-arming would miss. It drops `flow_en` between the two bytes, which a design that keeps the pending flag would complete. It also writes and reads with the key absent, where a broken gate would corrupt a register or leak its value. It sends bytes that equal only the second registers in single-byte mode, where a design would falsely suspend. Finally it gives pause and resume the same byte to check that pause wins.

// File: rtl/xonxoff_detector.sv
module xonxoff_detector #(
  parameter int W = 8,
  parameter logic [7:0] KEY = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flow_en,
  input  logic         two_byte,
  input  logic [7:0]   lcr_val,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         rx_out_valid,
  output logic [W-1:0] rx_out_data,
  output logic         xon_hit,
  output logic         xoff_hit,
  output logic         tx_enable
);

  logic [W-1:0] chr [4];
  logic pend_on, pend_off, suspended;

  wire gate_open = (lcr_val == KEY);
  wire take      = rx_valid & flow_en;

  wire eq_on_a  = (rx_data == chr[0]);
  wire eq_on_b  = (rx_data == chr[1]);
  wire eq_off_a = (rx_data == chr[2]);
  wire eq_off_b = (rx_data == chr[3]);

  wire off_now = take & (two_byte ? (pend_off & eq_off_b) : eq_off_a);
  wire on_now  = take & ~off_now & (two_byte ? (pend_on & eq_on_b) : eq_on_a);
  wire any_now = off_now | on_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) chr[i] <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && gate_open) chr[reg_addr] <= reg_wdata;
      reg_rdata <= (reg_rd && gate_open) ? chr[reg_addr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else if (!flow_en || !two_byte) begin
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else if (rx_valid) begin
      pend_on  <= eq_on_a  & ~any_now;
      pend_off <= eq_off_a & ~any_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      suspended    <= 1'b0;
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
      xon_hit      <= 1'b0;
      xoff_hit     <= 1'b0;
    end else begin
      rx_out_valid <= rx_valid;
      if (rx_valid) rx_out_data <= rx_data;
      xon_hit  <= on_now;
      xoff_hit <= off_now;
      if (!flow_en)     suspended <= 1'b0;
      else if (off_now) suspended <= 1'b1;
      else if (on_now)  suspended <= 1'b0;
    end
  end

  assign tx_enable = ~(suspended & flow_en);

endmodule

// File: rtl/xonxoff_detector_chk.sv
module xonxoff_detector_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flow_en,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_out_valid,
  input logic [W-1:0] rx_out_data,
  input logic         xon_hit,
  input logic         xoff_hit,
  input logic         tx_enable
);

  // R7
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xon_hit && xoff_hit));

  // R4
  off_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_hit && flow_en) |-> !tx_enable);

  // R4
  on_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xon_hit |-> tx_enable);

  // R8
  force_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |-> tx_enable);

  // R8
  no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !(xon_hit || xoff_hit));

  // R9
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_out_valid && rx_out_data == $past(rx_data)));

  // R9
  hit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_hit || xoff_hit) |-> rx_out_valid);

  // R10
  flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && $past(flow_en) && !xon_hit && !xoff_hit) |-> $stable(tx_enable));

endmodule

bind xonxoff_detector xonxoff_detector_chk #(.W(W)) u_chk (.*);

// File: tb/test_xonxoff_detector.sv
module test_xonxoff_detector;
  logic clk = 0, rst_n = 0, flow_en = 0, two_byte = 0;
  logic [7:0] lcr_val = 0, reg_wdata = 0, rx_data = 0;
  logic reg_wr = 0, reg_rd = 0, rx_valid = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_rdata, rx_out_data;
  logic rx_out_valid, xon_hit, xoff_hit, tx_enable;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  xonxoff_detector i_xonxoff_detector (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] key);
    @(negedge clk); lcr_val = key; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] key, input logic [7:0] exp, input string req);
    @(negedge clk); lcr_val = key; reg_rd = 1; reg_addr = a;
    @(posedge clk); #1; chk(req, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  // sends one byte and checks pass-through (R9), pulses and flag
  task automatic send(input logic [7:0] b, input bit eon, input bit eoff, input bit etx, input string req);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    chk("R9", {rx_out_valid, rx_out_data}, {1'b1, b});
    chk(req, {xon_hit, xoff_hit, tx_enable}, {eon, eoff, etx});
    @(negedge clk); rx_valid = 0;
    @(posedge clk); #1;
    chk("R9", {rx_out_valid, xon_hit, xoff_hit}, 0);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk("R1", {tx_enable, xon_hit, xoff_hit, rx_out_valid}, 4'b1000);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) rd(i[1:0], 8'hBF, 8'h00, "R1");
  endtask

  task automatic t_regs();
    wr(0, 8'h11, 8'hBF); wr(1, 8'h12, 8'hBF); wr(2, 8'h13, 8'hBF); wr(3, 8'h14, 8'hBF);
    rd(0, 8'hBF, 8'h11, "R2"); rd(1, 8'hBF, 8'h12, "R2");
    rd(2, 8'hBF, 8'h13, "R2"); rd(3, 8'hBF, 8'h14, "R2");
    wr(2, 8'hEE, 8'h03);
    rd(2, 8'h03, 8'h00, "R3");
    rd(2, 8'hBF, 8'h13, "R3");
  endtask

  task automatic t_one_byte();
    @(negedge clk); flow_en = 1; two_byte = 0;
    send(8'h14, 0, 0, 1, "R4");
    send(8'h12, 0, 0, 1, "R4");
    send(8'h13, 0, 1, 0, "R4");
    send(8'h55, 0, 0, 0, "R10");
    send(8'h11, 1, 0, 1, "R4");
  endtask

  task automatic t_two_byte();
    @(negedge clk); two_byte = 1;
    send(8'h13, 0, 0, 1, "R5");
    send(8'h14, 0, 1, 0, "R5");
    send(8'h11, 0, 0, 0, "R6");
    send(8'h55, 0, 0, 0, "R6");
    send(8'h12, 0, 0, 0, "R6");
    send(8'h11, 0, 0, 0, "R6");
    send(8'h11, 0, 0, 0, "R6");
    send(8'h12, 1, 0, 1, "R6");
  endtask

  task automatic t_disable();
    send(8'h13, 0, 0, 1, "R8");
    @(negedge clk); flow_en = 0;
    @(posedge clk);
    @(negedge clk); flow_en = 1;
    send(8'h14, 0, 0, 1, "R8");
    send(8'h13, 0, 0, 1, "R8");
    send(8'h14, 0, 1, 0, "R8");
    @(negedge clk); flow_en = 0; #1;
    chk("R8", tx_enable, 1);
    send(8'h11, 0, 0, 1, "R8");
    send(8'h13, 0, 0, 1, "R8");
  endtask

  task automatic t_tie();
    @(negedge clk); flow_en = 1; two_byte = 0;
    wr(2, 8'h11, 8'hBF);
    send(8'h11, 0, 1, 0, "R7");
    @(negedge clk); two_byte = 1;
    wr(3, 8'h12, 8'hBF);
    send(8'h11, 0, 0, 0, "R7");
    send(8'h12, 0, 1, 0, "R7");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_regs(); t_one_byte(); t_two_byte(); t_disable(); t_tie();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule